// File: doc/BRIEF.md
# Masked Calendar Alarm Matcher

This block watches a running calendar time (second, minute, hour, date, month, weekday) and compares it against two independent alarm settings. Every alarm field carries its own enable bit, so an alarm can be tied to one exact moment or repeat whenever the few enabled fields come round again. For example, enabling only the seconds field gives one match a minute. The comparison is made only on the cycle in which the timekeeping logic signals that the time has advanced. A match raises a sticky per-alarm flag that the host polls and clears. It also drives a shared active-low interrupt pin.

The interrupt pin works in one of two ways. It can stay low for as long as any flag is set, or it can give a single-cycle low pulse for each match. A two-bit frequency select can instead hand the pin over to a square wave taken from an oscillator divider. While that is selected the alarm drive is muted, but the flags keep working for polling.

Top module: `alarm_irq_matcher`

## Requirements
- R1: On a cycle with `tick` high, an alarm whose enabled fields all equal the current time sets its flag: `alarm_flags[0]` for alarm 0 and `alarm_flags[1]` for alarm 1. The flag is visible after the next rising clock edge.
- R2: Each alarm config is six bytes, packed with seconds in [7:0], minutes in [15:8], hours in [23:16], date in [31:24], month in [39:32] and weekday in [47:40]. In each byte, bit 7 is the enable and bits 6:0 are the value, which is compared with bits 6:0 of the matching time input. A field whose enable is 0 has no effect on the match.
- R3: An alarm with all six enable bits at 0 never sets its flag.
- R4: When `tick` is low, no flag is set, even if the time equals an alarm.
- R5: A flag stays set until a cycle with `clr_wr` high and the matching `clr_mask` bit at 1 clears it. Flags whose mask bit is 0 are left unchanged.
- R6: If a match and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: In hold mode (`pulse_mode`=0, `freq_sel`=00), `irq_n` is low while any flag is set and high otherwise.
- R8: In pulse mode (`pulse_mode`=1, `freq_sel`=00), `irq_n` is low for exactly the one cycle after a matching tick, and high at all other times, whatever the flags hold.
- R9: When `freq_sel` is not 00, `irq_n` carries the divided clock and no alarm activity affects it. The flags still set and clear as in R1 and R5.
- R10: The divider counts `osc_tick` pulses. With `osc_tick` high every cycle, `freq_sel` 01, 10 and 11 give periods of 2, 16 and 65536 clock cycles (32768 Hz, 4096 Hz and 1 Hz for a 65536 Hz tick).
- R11: After reset, `alarm_flags` is 00, `irq_n` is 1 and the divider is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-advanced strobe; compare enable |
| t_sec | input | 8 | Current seconds |
| t_min | input | 8 | Current minutes |
| t_hour | input | 8 | Current hours |
| t_date | input | 8 | Current date |
| t_month | input | 8 | Current month |
| t_wday | input | 8 | Current day of week |
| alm0_cfg | input | 48 | Alarm 0 fields with enables |
| alm1_cfg | input | 48 | Alarm 1 fields with enables |
| pulse_mode | input | 1 | 1 = pulse per match, 0 = hold |
| freq_sel | input | 2 | 00 alarm, 01/10/11 clock output |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 2 | Flags to clear (1 = clear) |
| osc_tick | input | 1 | Oscillator divider advance |
| alarm_flags | output | 2 | Sticky match flags |
| irq_n | output | 1 | Shared active-low interrupt / clock pin |

## Verification
A wrong field mask or wrong compare bits shows up as a flag that sets, or fails to set, one cycle after the offending tick. A flag register that loses or gains state shows up as an `irq_n` level in hold mode that disagrees with the expected flags on the very next sampled cycle. A faulty divider tap or mode mux changes how many rising edges `irq_n` shows in a fixed window, within at most two output periods.

// File: rtl/alarm_irq_matcher.sv
module alarm_irq_matcher #(
  parameter int DIV_BITS = 16,
  parameter int MID_TAP  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [7:0]  t_sec,
  input  logic [7:0]  t_min,
  input  logic [7:0]  t_hour,
  input  logic [7:0]  t_date,
  input  logic [7:0]  t_month,
  input  logic [7:0]  t_wday,
  input  logic [47:0] alm0_cfg,
  input  logic [47:0] alm1_cfg,
  input  logic        pulse_mode,
  input  logic [1:0]  freq_sel,
  input  logic        clr_wr,
  input  logic [1:0]  clr_mask,
  input  logic        osc_tick,
  output logic [1:0]  alarm_flags,
  output logic        irq_n
);
  localparam int NFLD = 6;

  logic [47:0] now;
  logic [1:0]  hit;
  logic [1:0]  flags_q;
  logic        pulse_q;
  logic [DIV_BITS-1:0] div_q;
  logic        tap;

  assign now = {t_wday, t_month, t_date, t_hour, t_min, t_sec};

  function automatic logic fields_match(input logic [47:0] cfg, input logic [47:0] cur);
    logic any, ok;
    any = 1'b0;
    ok  = 1'b1;
    for (int f = 0; f < NFLD; f++) begin
      if (cfg[8*f+7]) begin
        any = 1'b1;
        if (cfg[8*f +: 7] != cur[8*f +: 7]) ok = 1'b0;
      end
    end
    return any && ok;
  endfunction

  assign hit = {2{tick}} & {fields_match(alm1_cfg, now), fields_match(alm0_cfg, now)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pulse_q <= 1'b0;
      div_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~(clr_wr ? clr_mask : 2'b00)) | hit;
      pulse_q <= |hit;
      if (osc_tick) div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    case (freq_sel)
      2'b01:   tap = div_q[0];
      2'b10:   tap = div_q[MID_TAP];
      default: tap = div_q[DIV_BITS-1];
    endcase
  end

  assign alarm_flags = flags_q;
  assign irq_n = (freq_sel != 2'b00) ? tap
               : pulse_mode          ? ~pulse_q
               :                       ~(|flags_q);

  a_r4_no_tick_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_wr) |=> (alarm_flags == $past(alarm_flags)));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flags[0] && !(clr_wr && clr_mask[0])) |=> alarm_flags[0]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && clr_wr && clr_mask[1]) |=> alarm_flags[1]);

  a_r3_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!alm0_cfg[7] && !alm0_cfg[15] && !alm0_cfg[23] && !alm0_cfg[31] &&
     !alm0_cfg[39] && !alm0_cfg[47] && !alarm_flags[0]) |=> !alarm_flags[0]);

  a_r9_clock_only: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_sel != 2'b00 && $stable(freq_sel) && !$past(osc_tick)) |-> $stable(irq_n));
endmodule

// File: tb/tb_alarm_irq_matcher.sv
module tb_alarm_irq_matcher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] t_sec = 0, t_min = 0, t_hour = 0, t_date = 0, t_month = 0, t_wday = 0;
  logic [47:0] alm0_cfg = '0, alm1_cfg = '0;
  logic pulse_mode = 1'b0;
  logic [1:0] freq_sel = 2'b00;
  logic clr_wr = 1'b0;
  logic [1:0] clr_mask = 2'b00;
  logic osc_tick = 1'b0;
  logic [1:0] alarm_flags;
  logic irq_n;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    logic       chk_irq;
    logic       irq;
    logic [1:0] flags;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  alarm_irq_matcher dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_date(t_date),
    .t_month(t_month), .t_wday(t_wday),
    .alm0_cfg(alm0_cfg), .alm1_cfg(alm1_cfg),
    .pulse_mode(pulse_mode), .freq_sel(freq_sel),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .osc_tick(osc_tick),
    .alarm_flags(alarm_flags), .irq_n(irq_n)
  );

  function automatic logic [7:0] fld(input logic en, input logic [6:0] v);
    return {en, v};
  endfunction

  task automatic cyc(input logic tk, input logic cw, input logic [1:0] cm,
                     input logic ci, input logic ei, input logic [1:0] ef, input string req);
    exp_t e;
    tick = tk; clr_wr = cw; clr_mask = cm;
    e.chk_irq = ci; e.irq = ei; e.flags = ef; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    tick = 1'b0; clr_wr = 1'b0; clr_mask = 2'b00;
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (alarm_flags !== e.flags || (e.chk_irq && irq_n !== e.irq)) begin
        miscompares++;
        $display("FAIL %s: flags=%b irq_n=%b expected flags=%b irq_n=%b",
                 e.req, alarm_flags, irq_n, e.flags, e.chk_irq ? e.irq : 1'bx);
      end
    end
  end

  task automatic count_rises(input int n, input int exp_rises, input string req);
    int rises = 0;
    logic prev;
    @(posedge clk); #1;
    prev = irq_n;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (!prev && irq_n) rises++;
      prev = irq_n;
    end
    vectors++;
    if (rises != exp_rises) begin
      miscompares++;
      $display("FAIL %s: rising edges=%0d expected=%0d", req, rises, exp_rises);
    end
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, 2'b00, 1, 1, 2'b00, "R11 reset state");

    // R1/R2: seconds only enabled, minute field disabled with a different value
    alm0_cfg = {fld(0,7'h03), fld(0,7'h07), fld(0,7'h09), fld(0,7'h11), fld(0,7'h12), fld(1,7'h30)};
    alm1_cfg = '0;
    t_sec = 8'h30; t_min = 8'h45; t_hour = 8'h10; t_date = 8'h01; t_month = 8'h01; t_wday = 8'h02;
    cyc(1, 0, 2'b00, 1, 0, 2'b01, "R1 R2 R7 seconds match sets flag0");
    cyc(0, 0, 2'b00, 1, 0, 2'b01, "R5 flag sticky");
    cyc(0, 1, 2'b10, 1, 0, 2'b01, "R5 other mask bit leaves flag0");
    cyc(0, 1, 2'b01, 1, 1, 2'b00, "R5 R7 clear flag0");
    cyc(0, 0, 2'b00, 1, 1, 2'b00, "R4 equal time without tick");
    t_sec = 8'h31;
    cyc(1, 0, 2'b00, 1, 1, 2'b00, "R1 seconds mismatch");
    t_sec = 8'h30;
    cyc(1, 1, 2'b01, 1, 0, 2'b01, "R6 set beats clear");
    cyc(0, 1, 2'b01, 1, 1, 2'b00, "R5 clear after R6");

    // all fields enabled on alarm 1
    alm1_cfg = {fld(1,7'h02), fld(1,7'h01), fld(1,7'h01), fld(1,7'h10), fld(1,7'h45), fld(1,7'h30)};
    cyc(1, 0, 2'b00, 1, 0, 2'b11, "R1 both alarms match");
    cyc(0, 1, 2'b11, 1, 1, 2'b00, "R5 clear both");
    t_month = 8'h02;
    cyc(1, 0, 2'b00, 1, 0, 2'b01, "R2 enabled month mismatch blocks alarm1");
    cyc(0, 1, 2'b01, 1, 1, 2'b00, "R5 clear");

    // R3: no enables, values equal to time
    alm0_cfg = {fld(0,7'h02), fld(0,7'h02), fld(0,7'h01), fld(0,7'h10), fld(0,7'h45), fld(0,7'h30)};
    cyc(1, 0, 2'b00, 1, 1, 2'b00, "R3 no enabled field never fires");

    // R8 pulse mode
    alm0_cfg = {fld(0,7'h00), fld(0,7'h00), fld(0,7'h00), fld(0,7'h00), fld(0,7'h00), fld(1,7'h30)};
    pulse_mode = 1'b1;
    cyc(1, 0, 2'b00, 1, 0, 2'b01, "R8 pulse low after match");
    cyc(0, 0, 2'b00, 1, 1, 2'b01, "R8 pulse released with flag set");
    cyc(1, 0, 2'b00, 1, 0, 2'b01, "R8 second pulse");
    cyc(0, 0, 2'b00, 1, 1, 2'b01, "R8 second release");
    cyc(0, 1, 2'b01, 1, 1, 2'b00, "R5 clear in pulse mode");
    pulse_mode = 1'b0;

    // R9/R10 frequency output
    freq_sel = 2'b01;
    cyc(1, 0, 2'b00, 0, 1, 2'b01, "R9 flag sets while clock selected");
    cyc(0, 0, 2'b00, 0, 1, 2'b01, "R9 flag stays");
    osc_tick = 1'b1;
    count_rises(64, 32, "R9 R10 32768Hz tap with flag set");
    freq_sel = 2'b10;
    @(negedge clk);
    count_rises(64, 4, "R10 4096Hz tap");
    freq_sel = 2'b11;
    @(negedge clk);
    count_rises(131072, 2, "R10 1Hz tap");
    osc_tick = 1'b0;
    freq_sel = 2'b00;
    cyc(0, 0, 2'b00, 1, 0, 2'b01, "R7 back to hold with flag set");
    cyc(0, 1, 2'b01, 1, 1, 2'b00, "R5 final clear");
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule